// File: doc/BRIEF.md
# Stall-Time Fairness Request Arbiter

This arbiter picks one memory request per cycle from a set of candidates issued by several hardware threads. It counts, for each thread, the cycles that thread spends stalled on memory while sharing the controller. A separate estimator supplies the stall cycles each thread would have seen on its own. The ratio of the two is the thread's slowdown. The arbiter compares the largest slowdown with the smallest. When that spread goes past a programmable limit, the thread that has suffered most wins arbitration outright, even over requests that hit an open row.

While the spread stays at or under the limit, the arbiter uses ordinary open-row-first selection and breaks ties by age. Selection is combinational from the candidate inputs and the registered stall counters. A periodic epoch pulse clears the counters so that fairness is judged over a sliding window. The fraction is never computed directly: both the slowdown ordering and the spread test use cross-multiplied products.

Top module: `stf_arbiter`

## Requirements
- R1: Each cycle in which a thread's stall pulse is high (and no epoch clear occurs), that thread's shared stall counter rises by exactly one at the next clock edge. Otherwise the counter holds its value.
- R2: A shared stall counter that has reached its all-ones value stays there while further stall pulses arrive.
- R3: An epoch clear pulse zeroes every shared stall counter at the next clock edge. It takes precedence over a stall pulse in the same cycle.
- R4: A thread's slowdown is its shared stall count divided by its alone-stall estimate. An estimate of zero is treated as one.
- R5: The fairness override is active only when max slowdown / min slowdown is strictly greater than threshold/16 (threshold has 4 fractional bits). A spread exactly equal to the threshold leaves it inactive. When the minimum slowdown is zero and the maximum is nonzero, the spread counts as unbounded.
- R6: With the override active, any valid request from the most slowed-down thread beats every other request, whatever their row-hit flags. Among that thread's requests the order is row hit first, then largest age.
- R7: With the override inactive, a valid row-hit request beats any row-miss request. Within the same row-hit class, the request with the larger age value (older) wins.
- R8: Ties resolve to the lowest index: between requests with equal priority the lowest request slot wins, and between threads with equal maximum slowdown the lowest thread number is favoured.
- R9: grantValid is high exactly when at least one request valid bit is set. An invalid slot is never granted, whatever its row-hit flag or age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| epochClr | input | 1 | Clears all shared stall counters |
| stallPulse | input | NUM_THREADS | Per-thread memory stall indication for this cycle |
| aloneStall | input | NUM_THREADS*CNT_W | Per-thread alone-run stall estimate, thread t at bits [t*CNT_W +: CNT_W] |
| unfairThresh | input | THR_W | Spread limit, unsigned fixed point with 4 fractional bits |
| reqValid | input | NUM_REQ | Candidate slot occupied |
| reqThread | input | NUM_REQ*TID_W | Issuing thread of slot r at [r*TID_W +: TID_W] |
| reqRowHit | input | NUM_REQ | Slot targets the currently open row |
| reqAge | input | NUM_REQ*AGE_W | Slot age, larger is older, slot r at [r*AGE_W +: AGE_W] |
| grantValid | output | 1 | A request is granted this cycle |
| grantIdx | output | IDX_W | Index of the granted slot |

## Verification
Each stimulus pattern targets one priority rule in isolation. With balanced stall counts, mixes of hit and miss requests and of old and young ages show whether the fallback order is row-hit first, then age, then lowest slot. A single thread is then stalled far more than the rest. The grant moving to that thread's row-miss request over another thread's row hit shows that the override engages, and the limit is moved one LSB either side of the measured spread to show that the comparison is strict. Further cases vary the alone-stall estimate with the counts held fixed, clear the counters while a stall pulse is active, tie two threads at the top slowdown, and drive every counter into saturation. Each separates one of the counter or slowdown rules from its plausible mistake.

// File: rtl/stf_pkg.sv
package stf_pkg;
  localparam int TID_MAX_W = 4;

  typedef struct packed {
    logic                 fairOverride;
    logic [TID_MAX_W-1:0] favThread;
  } ctrlStrb_t;
endpackage

// File: rtl/stf_ctrl.sv
module stf_ctrl
  import stf_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 16,
  parameter int THR_W       = 8,
  parameter int FRAC_W      = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         epochClr,
  input  logic [NUM_THREADS-1:0]       stallPulse,
  input  logic [NUM_THREADS*CNT_W-1:0] aloneStall,
  input  logic [THR_W-1:0]             unfairThresh,
  output ctrlStrb_t                    strb
);
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int PROD_W = 2 * CNT_W;
  localparam int UNF_W  = 2 * CNT_W + THR_W + FRAC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] sharedCnt [NUM_THREADS];
  logic [CNT_W-1:0] aloneEff  [NUM_THREADS];

  // a slowdown greater than b slowdown, by cross-multiplication
  function automatic logic slowGt(input logic [CNT_W-1:0] aSh, input logic [CNT_W-1:0] aAl,
                                  input logic [CNT_W-1:0] bSh, input logic [CNT_W-1:0] bAl);
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    lhs = PROD_W'(aSh) * PROD_W'(bAl);
    rhs = PROD_W'(bSh) * PROD_W'(aAl);
    return lhs > rhs;
  endfunction

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] aloneRaw;
    assign aloneRaw    = aloneStall[t*CNT_W +: CNT_W];
    assign aloneEff[t] = (aloneRaw == '0) ? CNT_W'(1) : aloneRaw;

    always_ff @(posedge clk) begin
      if (!rstN || epochClr) begin
        sharedCnt[t] <= '0;
      end else if (stallPulse[t] && sharedCnt[t] != CNT_MAX) begin
        sharedCnt[t] <= sharedCnt[t] + 1'b1;
      end
    end

    // R1
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stallPulse[t] && !epochClr && sharedCnt[t] != CNT_MAX) |=> sharedCnt[t] == $past(sharedCnt[t]) + 1'b1);
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!stallPulse[t] && !epochClr) |=> $stable(sharedCnt[t]));
    // R2
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sharedCnt[t] == CNT_MAX && !epochClr) |=> sharedCnt[t] == CNT_MAX);
    // R3
    epoch_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      epochClr |=> sharedCnt[t] == '0);
  end

  logic [TID_W-1:0] maxIdx;
  logic [TID_W-1:0] minIdx;

  always_comb begin
    maxIdx = '0;
    minIdx = '0;
    for (int t = 1; t < NUM_THREADS; t++) begin
      if (slowGt(sharedCnt[t], aloneEff[t], sharedCnt[maxIdx], aloneEff[maxIdx])) begin
        maxIdx = TID_W'(t);
      end
      if (slowGt(sharedCnt[minIdx], aloneEff[minIdx], sharedCnt[t], aloneEff[t])) begin
        minIdx = TID_W'(t);
      end
    end
  end

  logic [UNF_W-1:0] spreadScaled;
  logic [UNF_W-1:0] limitScaled;

  always_comb begin
    spreadScaled = (UNF_W'(sharedCnt[maxIdx]) * UNF_W'(aloneEff[minIdx])) << FRAC_W;
    limitScaled  = UNF_W'(unfairThresh) * UNF_W'(sharedCnt[minIdx]) * UNF_W'(aloneEff[maxIdx]);
  end

  assign strb.fairOverride = spreadScaled > limitScaled;
  assign strb.favThread    = TID_MAX_W'(maxIdx);

  // R5
  no_stall_no_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(epochClr) |-> !strb.fairOverride);
endmodule

// File: rtl/stf_datapath.sv
module stf_datapath
  import stf_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int TID_W   = 2,
  parameter int AGE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [NUM_REQ*TID_W-1:0] reqThread,
  input  logic [NUM_REQ-1:0]       reqRowHit,
  input  logic [NUM_REQ*AGE_W-1:0] reqAge,
  output logic                     grantValid,
  output logic [((NUM_REQ > 1) ? $clog2(NUM_REQ) : 1)-1:0] grantIdx
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int KEY_W = AGE_W + 2;

  logic [NUM_REQ-1:0] isFav;
  logic [KEY_W-1:0]   reqKey [NUM_REQ];

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    assign isFav[r]  = strb.fairOverride &&
                       (TID_MAX_W'(reqThread[r*TID_W +: TID_W]) == strb.favThread);
    assign reqKey[r] = {isFav[r], reqRowHit[r], reqAge[r*AGE_W +: AGE_W]};
  end

  logic [KEY_W-1:0] bestKey;

  always_comb begin
    grantValid = 1'b0;
    grantIdx   = '0;
    bestKey    = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (reqValid[r] && (!grantValid || reqKey[r] > bestKey)) begin
        grantValid = 1'b1;
        grantIdx   = IDX_W'(r);
        bestKey    = reqKey[r];
      end
    end
  end

  logic anyFavValid;
  logic anyHitValid;
  logic grantFromFav;
  assign anyFavValid  = |(reqValid & isFav);
  assign anyHitValid  = |(reqValid & reqRowHit);
  assign grantFromFav = TID_MAX_W'(reqThread[int'(grantIdx)*TID_W +: TID_W]) == strb.favThread;

  // R9
  grant_is_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> reqValid[grantIdx]);
  // R9
  grant_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> grantValid);
  // R6
  fav_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fairOverride && anyFavValid) |-> grantFromFav);
  // R7
  hit_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.fairOverride && anyHitValid) |-> reqRowHit[grantIdx]);
endmodule

// File: rtl/stf_arbiter.sv
module stf_arbiter
  import stf_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_REQ     = 8,
  parameter int CNT_W       = 16,
  parameter int AGE_W       = 8,
  parameter int THR_W       = 8,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  parameter int IDX_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         epochClr,
  input  logic [NUM_THREADS-1:0]       stallPulse,
  input  logic [NUM_THREADS*CNT_W-1:0] aloneStall,
  input  logic [THR_W-1:0]             unfairThresh,
  input  logic [NUM_REQ-1:0]           reqValid,
  input  logic [NUM_REQ*TID_W-1:0]     reqThread,
  input  logic [NUM_REQ-1:0]           reqRowHit,
  input  logic [NUM_REQ*AGE_W-1:0]     reqAge,
  output logic                         grantValid,
  output logic [IDX_W-1:0]             grantIdx
);
  ctrlStrb_t strb;

  stf_ctrl #(
    .NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .THR_W(THR_W), .FRAC_W(4)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .epochClr(epochClr), .stallPulse(stallPulse),
    .aloneStall(aloneStall), .unfairThresh(unfairThresh), .strb(strb)
  );

  stf_datapath #(
    .NUM_REQ(NUM_REQ), .TID_W(TID_W), .AGE_W(AGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqValid(reqValid),
    .reqThread(reqThread), .reqRowHit(reqRowHit), .reqAge(reqAge),
    .grantValid(grantValid), .grantIdx(grantIdx)
  );
endmodule

// File: tb/tb_stf_arbiter.sv
`timescale 1ns/1ps
module tb_stf_arbiter;
  localparam int NT = 4;
  localparam int NR = 8;
  localparam int CW = 10;
  localparam int AW = 8;
  localparam int TW = 8;
  localparam int IW = 3;
  localparam int DW = 2;

  logic clk = 0;
  logic rstN = 0;
  logic epochClr = 0;
  logic [NT-1:0] stallPulse = '0;
  logic [NT*CW-1:0] aloneStall = '0;
  logic [TW-1:0] unfairThresh = 8'h20;
  logic [NR-1:0] reqValid = '0;
  logic [NR*DW-1:0] reqThread = '0;
  logic [NR-1:0] reqRowHit = '0;
  logic [NR*AW-1:0] reqAge = '0;
  logic grantValid;
  logic [IW-1:0] grantIdx;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  stf_arbiter #(.NUM_THREADS(NT), .NUM_REQ(NR), .CNT_W(CW), .AGE_W(AW), .THR_W(TW)) dut (
    .clk(clk), .rstN(rstN), .epochClr(epochClr), .stallPulse(stallPulse),
    .aloneStall(aloneStall), .unfairThresh(unfairThresh), .reqValid(reqValid),
    .reqThread(reqThread), .reqRowHit(reqRowHit), .reqAge(reqAge),
    .grantValid(grantValid), .grantIdx(grantIdx)
  );

  task automatic setReq(input int idx, input logic v, input int tid, input logic hit, input int age);
    reqValid[idx] = v;
    reqThread[idx*DW +: DW] = DW'(tid);
    reqRowHit[idx] = hit;
    reqAge[idx*AW +: AW] = AW'(age);
  endtask

  task automatic clearReqs();
    reqValid = '0; reqThread = '0; reqRowHit = '0; reqAge = '0;
  endtask

  task automatic setAlone(input int a0, input int a1, input int a2, input int a3);
    aloneStall = {CW'(a3), CW'(a2), CW'(a1), CW'(a0)};
  endtask

  task automatic pulseStall(input logic [NT-1:0] mask, input int n);
    @(negedge clk);
    stallPulse = mask;
    repeat (n) @(posedge clk);
    @(negedge clk);
    stallPulse = '0;
  endtask

  task automatic epoch(input logic [NT-1:0] withPulse);
    @(negedge clk);
    epochClr = 1'b1;
    stallPulse = withPulse;
    @(posedge clk);
    @(negedge clk);
    epochClr = 1'b0;
    stallPulse = '0;
  endtask

  task automatic checkGrant(input logic expV, input int expIdx, input string req);
    #1;
    checks++;
    if (grantValid !== expV || (expV && grantIdx !== IW'(expIdx))) begin
      failures++;
      $display("FAIL %s: grantValid=%0b grantIdx=%0d expected valid=%0b idx=%0d",
               req, grantValid, grantIdx, expV, expIdx);
    end
  endtask

  // R9 and reset: counters start at zero so no override
  task automatic testReset();
    @(negedge clk);
    clearReqs();
    checkGrant(1'b0, 0, "R9 empty after reset");
    @(negedge clk);
    setReq(3, 1, 0, 0, 0);
    setReq(4, 1, 2, 1, 0);
    checkGrant(1'b1, 4, "R5 zero counters no override");
  endtask

  // R7 and R8 in fallback order
  task automatic testHitOldest();
    @(negedge clk);
    clearReqs();
    setReq(2, 1, 0, 1, 3);
    setReq(5, 1, 1, 1, 9);
    setReq(6, 1, 2, 0, 200);
    checkGrant(1'b1, 5, "R7 hit then oldest");
    @(negedge clk);
    setReq(3, 1, 3, 1, 9);
    checkGrant(1'b1, 3, "R8 lowest slot on tie");
  endtask

  // R9 invalid slot ignored
  task automatic testInvalidIgnored();
    @(negedge clk);
    clearReqs();
    setReq(0, 0, 0, 1, 255);
    setReq(7, 1, 1, 0, 0);
    checkGrant(1'b1, 7, "R9 invalid slot not granted");
  endtask

  // R1 balanced counts keep fallback order
  task automatic testBalanced();
    setAlone(10, 10, 10, 10);
    pulseStall(4'hF, 10);
    @(negedge clk);
    clearReqs();
    setReq(0, 1, 2, 0, 50);
    setReq(1, 1, 0, 1, 1);
    checkGrant(1'b1, 1, "R7 balanced slowdown no override");
  endtask

  // R6 override beats row hit
  task automatic testOverride();
    pulseStall(4'b0100, 30);
    @(negedge clk);
    checkGrant(1'b1, 0, "R6 favoured miss beats hit");
    @(negedge clk);
    setReq(4, 1, 2, 1, 0);
    checkGrant(1'b1, 4, "R6 hit first within favoured");
  endtask

  // R5 strict comparison at the limit (spread is exactly 4.0)
  task automatic testThreshold();
    @(negedge clk);
    unfairThresh = 8'h40;
    checkGrant(1'b1, 1, "R5 equal spread no override");
    @(negedge clk);
    unfairThresh = 8'h3F;
    checkGrant(1'b1, 4, "R5 spread above limit overrides");
    @(negedge clk);
    unfairThresh = 8'h20;
  endtask

  // R4 alone estimate changes slowdown
  task automatic testAlone();
    @(negedge clk);
    setAlone(10, 10, 40, 10);
    checkGrant(1'b1, 1, "R4 larger alone estimate removes override");
    @(negedge clk);
    clearReqs();
    setReq(3, 1, 0, 0, 0);
    setReq(4, 1, 2, 1, 0);
    setAlone(1, 10, 40, 10);
    checkGrant(1'b1, 3, "R4 smaller alone estimate favours thread 0");
    @(negedge clk);
    setAlone(0, 10, 40, 10);
    checkGrant(1'b1, 3, "R4 zero estimate acts as one");
  endtask

  // R3 clear wins over concurrent pulse
  task automatic testEpoch();
    setAlone(10, 10, 10, 10);
    epoch(4'b0001);
    checkGrant(1'b1, 4, "R3 epoch clear beats stall pulse");
  endtask

  // R8 tied top threads, R5 zero minimum
  task automatic testFavTie();
    pulseStall(4'b1010, 20);
    @(negedge clk);
    clearReqs();
    setReq(0, 1, 3, 1, 100);
    setReq(2, 1, 1, 0, 0);
    setReq(5, 1, 0, 1, 200);
    checkGrant(1'b1, 2, "R8 lowest thread among tied maxima");
  endtask

  // R2 saturation keeps threads equal
  task automatic testSaturate();
    epoch(4'b0000);
    setAlone(1, 1, 1, 1);
    pulseStall(4'hF, 1030);
    pulseStall(4'b0001, 50);
    @(negedge clk);
    clearReqs();
    setReq(3, 1, 0, 0, 0);
    setReq(4, 1, 2, 1, 0);
    checkGrant(1'b1, 4, "R2 saturated counters stay equal");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    testReset();
    testHitOldest();
    testInvalidIgnored();
    testBalanced();
    testOverride();
    testThreshold();
    testAlone();
    testEpoch();
    testFavTie();
    testSaturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule